// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, called side A and side B, and moves data between them in either direction. Each side owns a storage register that samples that side's bus on the rising edge of a clock dedicated to that side. For each direction there is a source select. It chooses between the data present right now on the opposite bus and the value that the opposite side's register last captured. An output enable for each direction decides whether that direction drives at all.

Each direction's drive is presented as a value plus a drive-enable, which suits a pad or a tri-state buffer outside the block. When a direction is disabled, its drive-enable is low and its value output is held at zero. A build-time parameter gives either a straight data path or an inverting one. Inversion acts only on the outgoing values, and the registers always keep the bus data as it was sampled.

A register keeps sampling its own bus even while the block is driving that bus. Looping a driven bus back into its input therefore stores the transmitted word, which can then be replayed in the other direction. It is illegal use to enable both directions with live data selected on both, because the buses would then drive each other.

Top module: `bus_xcvr`

## Requirements
- R1: An active-low asynchronous reset (`rstN`) clears both storage registers to all zeros without any clock edge. In the inverting variant, a stored zero is therefore driven as all ones.
- R2: The side-A register loads `aIn` on each rising edge of `clkA` and holds its value across edges of `clkB` and across changes of `aIn` between `clkA` edges.
- R3: The side-B register loads `bIn` on each rising edge of `clkB` and holds its value across edges of `clkA` and across changes of `bIn` between `clkB` edges.
- R4: When `oeAB` is 1, `bOutEn` is 1 and `bOut` carries the selected A-side data. When `oeAB` is 0, `bOutEn` is 0 and `bOut` is all zeros.
- R5: `oeBAn` is active low. When `oeBAn` is 0, `aOutEn` is 1 and `aOut` carries the selected B-side data. When `oeBAn` is 1, `aOutEn` is 0 and `aOut` is all zeros.
- R6: `selAB` = 0 drives `bOut` from the live `aIn`. `selAB` = 1 drives it from the side-A register.
- R7: `selBA` = 0 drives `aOut` from the live `bIn`. `selBA` = 1 drives it from the side-B register.
- R8: With `INVERT` = 1, both `aOut` and `bOut` are the bitwise complement of the selected source while enabled. The registers still hold the non-inverted sampled data. With `INVERT` = 0, outputs equal the source.
- R9: A register samples its bus even while the block drives that bus. Feeding `bOut` back to `bIn` and pulsing `clkB` stores the driven word, which `selBA` = 1 then returns on `aOut`.
- R10: The bus width is the parameter `WIDTH`, which defaults to 8 bits on all four data ports.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkA | input | 1 | Side-A register clock, rising edge |
| clkB | input | 1 | Side-B register clock, rising edge |
| rstN | input | 1 | Asynchronous reset of both registers, active low |
| oeAB | input | 1 | Enable for driving side B, active high |
| oeBAn | input | 1 | Enable for driving side A, active low |
| selAB | input | 1 | Source of B-side drive: 0 live A, 1 stored A |
| selBA | input | 1 | Source of A-side drive: 0 live B, 1 stored B |
| aIn | input | WIDTH | Data seen on bus A |
| bIn | input | WIDTH | Data seen on bus B |
| aOut | output | WIDTH | Value driven onto bus A |
| aOutEn | output | 1 | Drive enable for bus A |
| bOut | output | WIDTH | Value driven onto bus B |
| bOutEn | output | 1 | Drive enable for bus B |

## Verification
Several properties are checked at every register clock edge. Each register must equal the bus value from its previous edge. A disabled direction must present zeros. An enabled direction that selects stored data must show the register with the build's polarity.

Other behaviours only show up in the bench's scenarios. These include an asynchronous reset applied with no clock running, holding a register across the other side's clock, live pass-through in both polarities, and the loopback capture that stores a word the block itself is driving and later replays it on the other side.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Strobes from the control decode to the datapath
  typedef struct packed {
    logic driveB;    // side B is driven
    logic driveA;    // side A is driven
    logic pickRegA;  // B-side drive takes the A register
    logic pickRegB;  // A-side drive takes the B register
  } xcvr_strobe_t;

endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic         oeAB,
  input  logic         oeBAn,
  input  logic         selAB,
  input  logic         selBA,
  output xcvr_strobe_t strobe
);

  always_comb begin
    strobe          = '0;
    strobe.driveB   = oeAB;
    strobe.driveA   = ~oeBAn;
    strobe.pickRegA = selAB;
    strobe.pickRegB = selBA;
  end

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             clkA,
  input  logic             clkB,
  input  logic             rstN,
  input  xcvr_strobe_t     strobe,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOutEn,
  output logic [WIDTH-1:0] bOut,
  output logic             bOutEn
);

  localparam logic [WIDTH-1:0] POL_MASK = INVERT ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

  logic [WIDTH-1:0] regA;
  logic [WIDTH-1:0] regB;
  logic [WIDTH-1:0] srcToB;
  logic [WIDTH-1:0] srcToA;
  logic [WIDTH-1:0] polToB;
  logic [WIDTH-1:0] polToA;

  // Side-A storage, own clock
  always_ff @(posedge clkA or negedge rstN) begin
    if (!rstN) regA <= '0;
    else       regA <= aIn;
  end

  // Side-B storage, own clock
  always_ff @(posedge clkB or negedge rstN) begin
    if (!rstN) regB <= '0;
    else       regB <= bIn;
  end

  // Source selection per direction
  assign srcToB = strobe.pickRegA ? regA : aIn;
  assign srcToA = strobe.pickRegB ? regB : bIn;

  // Polarity variant chosen at build time
  generate
    if (INVERT) begin : g_inv
      assign polToB = ~srcToB;
      assign polToA = ~srcToA;
    end else begin : g_true
      assign polToB = srcToB;
      assign polToA = srcToA;
    end
  endgenerate

  // Drive gating
  assign bOutEn = strobe.driveB;
  assign aOutEn = strobe.driveA;
  assign bOut   = strobe.driveB ? polToB : '0;
  assign aOut   = strobe.driveA ? polToA : '0;

  AST_REGA_LOAD: assert property (@(posedge clkA) disable iff (!rstN)
    1'b1 |=> (regA == $past(aIn))); // R2

  AST_REGB_LOAD: assert property (@(posedge clkB) disable iff (!rstN)
    1'b1 |=> (regB == $past(bIn))); // R3

  AST_B_IDLE: assert property (@(posedge clkA) disable iff (!rstN)
    !bOutEn |-> (bOut == '0)); // R4

  AST_A_IDLE: assert property (@(posedge clkB) disable iff (!rstN)
    !aOutEn |-> (aOut == '0)); // R5

  AST_B_STORED: assert property (@(posedge clkB) disable iff (!rstN)
    (bOutEn && strobe.pickRegA) |-> (bOut == (regA ^ POL_MASK))); // R6

  AST_A_STORED: assert property (@(posedge clkA) disable iff (!rstN)
    (aOutEn && strobe.pickRegB) |-> (aOut == (regB ^ POL_MASK))); // R7

endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             clkA,
  input  logic             clkB,
  input  logic             rstN,
  input  logic             oeAB,
  input  logic             oeBAn,
  input  logic             selAB,
  input  logic             selBA,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOutEn,
  output logic [WIDTH-1:0] bOut,
  output logic             bOutEn
);

  xcvr_strobe_t strobe;

  xcvr_ctrl u_ctrl (
    .oeAB   (oeAB),
    .oeBAn  (oeBAn),
    .selAB  (selAB),
    .selBA  (selBA),
    .strobe (strobe)
  );

  xcvr_path #(
    .WIDTH  (WIDTH),
    .INVERT (INVERT)
  ) u_path (
    .clkA   (clkA),
    .clkB   (clkB),
    .rstN   (rstN),
    .strobe (strobe),
    .aIn    (aIn),
    .bIn    (bIn),
    .aOut   (aOut),
    .aOutEn (aOutEn),
    .bOut   (bOut),
    .bOutEn (bOutEn)
  );

endmodule

// File: tb/bus_xcvr_tb.sv
module bus_xcvr_tb;
  localparam int W = 8;

  typedef struct {
    string      req;
    bit         inv;
    logic       expAEn;
    logic [W-1:0] expA;
    logic       expBEn;
    logic [W-1:0] expB;
  } item_t;

  logic clk = 1'b0;
  logic clkA = 1'b0, clkB = 1'b0, rstN = 1'b0;
  logic oeAB = 1'b0, oeBAn = 1'b1, selAB = 1'b0, selBA = 1'b0;
  logic loopB = 1'b0;
  logic [W-1:0] aIn = '0, bDrv = '0;
  logic [W-1:0] bIn0, aOut0, bOut0, aOut1, bOut1;
  logic aEn0, bEn0, aEn1, bEn1;

  logic [W-1:0] mRegA = '0, mRegB0 = '0, mRegB1 = '0;
  int compared = 0, mismatched = 0;
  int cycles = 0;
  item_t q[$];
  event sampleEv;

  always #10 clk = ~clk;  // 50 MHz

  assign bIn0 = loopB ? bOut0 : bDrv;

  bus_xcvr #(.WIDTH(W), .INVERT(1'b0)) u_dut (
    .clkA(clkA), .clkB(clkB), .rstN(rstN), .oeAB(oeAB), .oeBAn(oeBAn),
    .selAB(selAB), .selBA(selBA), .aIn(aIn), .bIn(bIn0),
    .aOut(aOut0), .aOutEn(aEn0), .bOut(bOut0), .bOutEn(bEn0));

  bus_xcvr #(.WIDTH(W), .INVERT(1'b1)) u_dutInv (
    .clkA(clkA), .clkB(clkB), .rstN(rstN), .oeAB(oeAB), .oeBAn(oeBAn),
    .selAB(selAB), .selBA(selBA), .aIn(aIn), .bIn(bDrv),
    .aOut(aOut1), .aOutEn(aEn1), .bOut(bOut1), .bOutEn(bEn1));

  function automatic item_t model(string req, bit inv);
    item_t it;
    logic [W-1:0] mask = inv ? '1 : '0;
    logic [W-1:0] regB = inv ? mRegB1 : mRegB0;
    it.req    = req;
    it.inv    = inv;
    it.expBEn = oeAB;
    it.expB   = oeAB ? ((selAB ? mRegA : aIn) ^ mask) : '0;
    it.expAEn = ~oeBAn;
    it.expA   = !oeBAn ? ((selBA ? regB : bDrv) ^ mask) : '0;
    return it;
  endfunction

  // Driver side: push expectations for both variants
  task automatic expectNow(string req);
    q.push_back(model(req, 1'b0));
    q.push_back(model(req, 1'b1));
    -> sampleEv;
    #4;
  endtask

  // Monitor side: pop and compare against the outputs
  initial begin
    forever begin
      @sampleEv;
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic gAEn, gBEn;
        logic [W-1:0] gA, gB;
        it = q.pop_front();
        gAEn = it.inv ? aEn1 : aEn0;
        gBEn = it.inv ? bEn1 : bEn0;
        gA   = it.inv ? aOut1 : aOut0;
        gB   = it.inv ? bOut1 : bOut0;
        compared++;
        if (gAEn !== it.expAEn || gA !== it.expA || gBEn !== it.expBEn || gB !== it.expB) begin
          mismatched++;
          $display("FAIL %s inv=%0d: got aEn=%b a=%h bEn=%b b=%h expected aEn=%b a=%h bEn=%b b=%h",
                   it.req, it.inv, gAEn, gA, gBEn, gB, it.expAEn, it.expA, it.expBEn, it.expB);
        end
      end
    end
  end

  task automatic pulseA();
    #5 clkA = 1'b1; mRegA = aIn;
    #10 clkA = 1'b0; #5;
  endtask

  task automatic pulseB();
    #5 clkB = 1'b1; mRegB0 = bIn0; mRegB1 = bDrv;
    #10 clkB = 1'b0; #5;
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 100000) begin
      mismatched++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      finishRun();
    end
  end

  initial begin
    // R1: reset state seen through stored selects on both sides
    oeAB = 1; selAB = 1; oeBAn = 0; selBA = 1;
    #3; expectNow("R1 reset");
    rstN = 1; #10;

    // R4: B side disabled
    oeAB = 0; oeBAn = 1; aIn = 8'hA5;
    expectNow("R4 disabled");
    // R6 live A to B; R5 A side off
    oeAB = 1; selAB = 0;
    expectNow("R6 live");
    aIn = 8'h0F; expectNow("R8 live polarity");

    // R2: load A register, then change aIn
    aIn = 8'h3C; pulseA();
    aIn = 8'hFF; selAB = 1;
    expectNow("R2 stored A");
    // R2: hold across clkB edge
    bDrv = 8'h55; pulseB();
    aIn = 8'h12;
    expectNow("R2 hold on clkB");

    // R3: load B register
    bDrv = 8'h81; pulseB();
    bDrv = 8'h00; oeAB = 0; oeBAn = 0; selBA = 1;
    expectNow("R3 stored B");
    // R3: hold across clkA
    aIn = 8'h77; pulseA();
    expectNow("R3 hold on clkA");

    // R7: live B to A; R5 enable
    selBA = 0; bDrv = 8'hC9;
    expectNow("R7 live");
    // R5: A side disabled
    oeBAn = 1;
    expectNow("R5 disabled");

    // R9: loopback capture of driven word
    oeAB = 1; selAB = 0; aIn = 8'hC3; bDrv = 8'h11; loopB = 1;
    #2; pulseB();
    loopB = 0; bDrv = 8'h00; oeAB = 0; oeBAn = 0; selBA = 1;
    expectNow("R9 loopback");

    // R1: asynchronous reset without clocks
    oeAB = 1; selAB = 1;
    rstN = 0; mRegA = '0; mRegB0 = '0; mRegB1 = '0;
    #3; expectNow("R1 async reset");
    rstN = 1; #10;

    // R10: default width
    compared++;
    if ($bits(bOut0) != 8) begin
      mismatched++;
      $display("FAIL R10: got %0d expected 8", $bits(bOut0));
    end

    #20;
    finishRun();
  end

endmodule